// File: doc/BRIEF.md
# Time-Multiplexed Two-Variable Spiking Neuron Engine

This block advances sixteen simple spiking neurons by one integration step each time a step strobe arrives. Every neuron carries two signed fixed-point state values: a fast, membrane-like value `v` and a slower recovery value `n`. On a strobe, the engine visits the neurons one after another, in index order. For each one it computes a forward-Euler update through a single shared squaring multiplier, writes the new state back, and raises that neuron's spike flag if `v` crossed from non-positive to positive.

The fast variable settles towards an N-shaped curve built from two quadratic branches that meet at `v = 0`. The recovery variable relaxes towards a second curve that is quadratic on each side of zero. Every multiplication by a model constant uses one or two arithmetic right shifts and an add. A one-bit mode input picks one of two constant sets. One set gives the slow-onset firing family (class 1). The other gives the graded-amplitude firing family (class 2). A surrounding network supplies one stimulus word per neuron, holds it while the pass runs, and reads back the state and spike flags after the completion pulse.

Top module: `qn_neuron_core`

## Requirements
- R1: While reset is high and afterwards until the first pass, every `v`, `n` and spike flag is zero and `done_o` is low.
- R2: All values are 18-bit two's complement with 12 fractional bits. Every intermediate and final result is clamped to the range -131072..131071 instead of wrapping.
- R3: With `p = clamp(floor(v*v / 4096))`, the shape curves are:
  - For `v < 0`: `f = clamp(-K_fneg(p))` and `g = K_gneg(p)`.
  - For `v >= 0`: `f = clamp(K_fsq(p) - K_flin(v))` and `g = K_gpos(p)`.
- R4: The update is:
  - `v' = clamp(v + K_vstep(clamp(f - n + bias + stim)))`
  - `n' = clamp(n + K_nstep(clamp(g - n)))`
  
  A gain `K(x)` is `(x >>> a)` or `(x >>> a) + (x >>> b)`, clamped.
- R5: When `class_sel_i` is 0 (class 1), the constants are:
  - fneg = 1, fsq = 1, flin = 1
  - gneg = 1/2, gpos = 1 + 1/2
  - vstep = 1/8, nstep = 1/64 + 1/128
  - bias = 256
  
  When `class_sel_i` is 1 (class 2), the constants are:
  - fneg = 1, fsq = 1/2, flin = 1/2 + 1/4
  - gneg = 1/4, gpos = 1
  - vstep = 1/8 + 1/16, nstep = 1/16
  - bias = -512
  
  The mode is captured with the accepted strobe and is held for the whole pass.
- R6: A neuron's spike flag is written at that neuron's update. It is 1 exactly when the old `v <= 0` and the new `v > 0`, and it holds until the neuron's next update.
- R7: A strobe accepted while idle starts a pass. Neuron k (bits `18k+17:18k` of every bus) is written at the (k+1)-th rising edge after acceptance, using the stimulus present at that edge.
- R8: `done_o` is high for exactly one cycle, starting right after neuron 15 is written, so it is first seen 16 cycles after the strobe is accepted.
- R9: A strobe that arrives during a pass is ignored. While idle, `v_o`, `n_o` and `spike_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Integration strobe; accepted only while idle |
| class_sel_i | input | 1 | Constant set: 0 selects class 1, 1 selects class 2 |
| stim_i | input | 288 | Per-neuron stimulus, 18 bits each, neuron k in bits 18k+17:18k |
| v_o | output | 288 | Fast state of every neuron |
| n_o | output | 288 | Recovery state of every neuron |
| spike_o | output | 16 | Per-neuron upward-crossing flag |
| done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
The bound checker watches, on every cycle, that:
- a raised spike flag always sits on a positive `v` that was non-positive one cycle earlier;
- the state stays frozen whenever no pass runs;
- the completion pulse lasts one cycle and follows an active pass.

Only the bench's scenarios can show the exact arithmetic: both quadratic branches, both constant sets, clamping under extreme stimulus, and the per-neuron ordering within a pass. They are also the only way to show that a strobe or mode change during a pass has no effect on the results.

// File: rtl/qn_pkg.sv
package qn_pkg;

    localparam int DW = 18;
    localparam int FW = 12;
    localparam int XW = DW + 22;

    typedef logic signed [DW-1:0] fx_t;
    typedef logic signed [XW-1:0] wide_t;

    localparam wide_t FX_HI = wide_t'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam wide_t FX_LO = -FX_HI - wide_t'(64'sd1);

    typedef enum logic {
        MODE_CLASS1 = 1'b0,
        MODE_CLASS2 = 1'b1
    } nmode_e;

    // gain = 2^-sa, plus 2^-sb when twin is set
    typedef struct packed {
        logic [3:0] sa;
        logic [3:0] sb;
        logic       twin;
    } gain_t;

    typedef struct packed {
        gain_t fneg;
        gain_t fsq;
        gain_t flin;
        gain_t gneg;
        gain_t gpos;
        gain_t vstep;
        gain_t nstep;
        fx_t   bias;
    } pset_t;

    function automatic fx_t clamp(input wide_t x);
        if (x > FX_HI) return FX_HI[DW-1:0];
        if (x < FX_LO) return FX_LO[DW-1:0];
        return x[DW-1:0];
    endfunction

    function automatic fx_t scale(input fx_t x, input gain_t g);
        wide_t xw;
        wide_t acc;
        xw  = wide_t'(x);
        acc = xw >>> g.sa;
        if (g.twin) acc = acc + (xw >>> g.sb);
        return clamp(acc);
    endfunction

    function automatic gain_t mk_gain(input int a, input int b, input bit two);
        gain_t g;
        g.sa   = 4'(a);
        g.sb   = 4'(b);
        g.twin = two;
        return g;
    endfunction

    function automatic pset_t params_for(input nmode_e m);
        pset_t p;
        if (m == MODE_CLASS1) begin
            p.fneg  = mk_gain(0, 0, 1'b0);
            p.fsq   = mk_gain(0, 0, 1'b0);
            p.flin  = mk_gain(0, 0, 1'b0);
            p.gneg  = mk_gain(1, 0, 1'b0);
            p.gpos  = mk_gain(0, 1, 1'b1);
            p.vstep = mk_gain(3, 0, 1'b0);
            p.nstep = mk_gain(6, 7, 1'b1);
            p.bias  = fx_t'(256);
        end else begin
            p.fneg  = mk_gain(0, 0, 1'b0);
            p.fsq   = mk_gain(1, 0, 1'b0);
            p.flin  = mk_gain(1, 2, 1'b1);
            p.gneg  = mk_gain(2, 0, 1'b0);
            p.gpos  = mk_gain(0, 0, 1'b0);
            p.vstep = mk_gain(3, 4, 1'b1);
            p.nstep = mk_gain(4, 0, 1'b0);
            p.bias  = fx_t'(-512);
        end
        return p;
    endfunction

endpackage

// File: rtl/qn_update.sv
module qn_update
    import qn_pkg::*;
(
    input  fx_t   v_cur,
    input  fx_t   n_cur,
    input  fx_t   stim,
    input  pset_t ps,
    output fx_t   v_nxt,
    output fx_t   n_nxt,
    output logic  fire
);

    wide_t sq_full;
    fx_t   sq;
    fx_t   f_val;
    fx_t   g_val;
    fx_t   dv;
    fx_t   dn;
    logic  neg;

    always_comb begin
        neg     = v_cur[DW-1];
        // the single variable-by-variable product of the step
        sq_full = wide_t'(v_cur) * wide_t'(v_cur);
        sq      = clamp(sq_full >>> FW);
        if (neg) begin
            f_val = clamp(-wide_t'(scale(sq, ps.fneg)));
            g_val = scale(sq, ps.gneg);
        end else begin
            f_val = clamp(wide_t'(scale(sq, ps.fsq)) - wide_t'(scale(v_cur, ps.flin)));
            g_val = scale(sq, ps.gpos);
        end
        dv    = clamp(wide_t'(f_val) - wide_t'(n_cur) + wide_t'(ps.bias) + wide_t'(stim));
        dn    = clamp(wide_t'(g_val) - wide_t'(n_cur));
        v_nxt = clamp(wide_t'(v_cur) + wide_t'(scale(dv, ps.vstep)));
        n_nxt = clamp(wide_t'(n_cur) + wide_t'(scale(dn, ps.nstep)));
        fire  = (neg || (v_cur == '0)) && !v_nxt[DW-1] && (v_nxt != '0);
    end

endmodule

// File: rtl/qn_seq.sv
module qn_seq #(
    parameter  int N_NEURONS = 16,
    localparam int IW        = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic          busy,
    output logic [IW-1:0] idx,
    output logic          done
);

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } sq_e;

    localparam logic [IW-1:0] LAST = IW'(N_NEURONS - 1);

    sq_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SQ_IDLE;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (step) begin
                        st  <= SQ_RUN;
                        idx <= '0;
                    end
                end
                SQ_RUN: begin
                    if (idx == LAST) begin
                        st   <= SQ_IDLE;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy = (st == SQ_RUN);

endmodule

// File: rtl/qn_neuron_core.sv
module qn_neuron_core
    import qn_pkg::*;
#(
    parameter  int N_NEURONS = 16,
    localparam int IW        = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_i,
    input  logic                    class_sel_i,
    input  logic [N_NEURONS*DW-1:0] stim_i,
    output logic [N_NEURONS*DW-1:0] v_o,
    output logic [N_NEURONS*DW-1:0] n_o,
    output logic [N_NEURONS-1:0]    spike_o,
    output logic                    done_o
);

    fx_t v_q [N_NEURONS];
    fx_t n_q [N_NEURONS];

    logic          run_active;
    logic [IW-1:0] cur;
    nmode_e        mode_q;
    pset_t         ps;
    fx_t           v_sel;
    fx_t           n_sel;
    fx_t           stim_sel;
    fx_t           v_upd;
    fx_t           n_upd;
    logic          fire;

    qn_seq #(.N_NEURONS(N_NEURONS)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .step (step_i),
        .busy (run_active),
        .idx  (cur),
        .done (done_o)
    );

    // constant set is frozen for the whole pass
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_CLASS1;
        end else if (step_i && !run_active) begin
            mode_q <= nmode_e'(class_sel_i);
        end
    end

    assign ps = params_for(mode_q);

    always_comb begin
        v_sel    = v_q[cur];
        n_sel    = n_q[cur];
        stim_sel = stim_i[cur*DW +: DW];
    end

    qn_update u_upd (
        .v_cur (v_sel),
        .n_cur (n_sel),
        .stim  (stim_sel),
        .ps    (ps),
        .v_nxt (v_upd),
        .n_nxt (n_upd),
        .fire  (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N_NEURONS; k++) begin
                v_q[k] <= '0;
                n_q[k] <= '0;
            end
            spike_o <= '0;
        end else if (run_active) begin
            v_q[cur]     <= v_upd;
            n_q[cur]     <= n_upd;
            spike_o[cur] <= fire;
        end
    end

    for (genvar g = 0; g < N_NEURONS; g++) begin : g_out
        assign v_o[g*DW +: DW] = v_q[g];
        assign n_o[g*DW +: DW] = n_q[g];
    end

endmodule

// File: rtl/qn_checker.sv
module qn_checker
    import qn_pkg::*;
#(
    parameter int N_NEURONS = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    busy,
    input logic                    done_o,
    input logic [N_NEURONS*DW-1:0] v_o,
    input logic [N_NEURONS*DW-1:0] n_o,
    input logic [N_NEURONS-1:0]    spike_o
);

    for (genvar i = 0; i < N_NEURONS; i++) begin : g_spk
        // R6: a flag that is up sits on a positive fast state
        a_r6_flag_on_positive: assert property (@(posedge clk) disable iff (rst)
            spike_o[i] |-> ($signed(v_o[i*DW +: DW]) > 0));
        // R6: a flag only rises when the fast state was non-positive before
        a_r6_rise_from_nonpos: assert property (@(posedge clk) disable iff (rst)
            $rose(spike_o[i]) |-> ($past($signed(v_o[i*DW +: DW])) <= 0));
    end

    // R9: nothing moves while no pass runs
    a_r9_idle_frozen: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(v_o) && $stable(n_o) && $stable(spike_o)));

    // R8: completion pulse is one cycle wide
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: completion pulse closes an active pass and leaves the engine idle
    a_r8_done_after_pass: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy) && !busy));

endmodule

bind qn_neuron_core qn_checker #(.N_NEURONS(N_NEURONS)) u_qn_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (run_active),
    .done_o  (done_o),
    .v_o     (v_o),
    .n_o     (n_o),
    .spike_o (spike_o)
);

// File: tb/test_qn_neuron_core.sv
module test_qn_neuron_core;

    localparam int N  = 16;
    localparam int DW = 18;

    // gain table [mode][fneg,fsq,flin,gneg,gpos,vstep,nstep][a,b,two]
    localparam int GT [2][7][3] = '{
        '{'{0,0,0}, '{0,0,0}, '{0,0,0}, '{1,0,0}, '{0,1,1}, '{3,0,0}, '{6,7,1}},
        '{'{0,0,0}, '{1,0,0}, '{1,2,1}, '{2,0,0}, '{0,0,0}, '{3,4,1}, '{4,0,0}}
    };
    localparam longint BIAS [2] = '{256, -512};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 step_i = 1'b0;
    logic                 class_sel_i = 1'b0;
    logic [N*DW-1:0]      stim_i;
    logic [N*DW-1:0]      v_o;
    logic [N*DW-1:0]      n_o;
    logic [N-1:0]         spike_o;
    logic                 done_o;
    logic signed [DW-1:0] stim_a [N];

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) stim_i[i*DW +: DW] = stim_a[i];
    end

    qn_neuron_core i_qn_neuron_core (
        .clk         (clk),
        .rst         (rst),
        .step_i      (step_i),
        .class_sel_i (class_sel_i),
        .stim_i      (stim_i),
        .v_o         (v_o),
        .n_o         (n_o),
        .spike_o     (spike_o),
        .done_o      (done_o)
    );

    typedef struct {
        longint v;
        longint n;
        bit     s;
        string  tag;
    } exp_t;

    exp_t   sb [$];
    int     checks = 0;
    int     fails = 0;
    int     pass_cnt = 0;
    int     exp_passes = 0;
    longint mv [N];
    longint mn [N];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint bsat(input longint x);
        if (x > 131071) return 131071;
        if (x < -131072) return -131072;
        return x;
    endfunction

    function automatic longint kg(input longint x, input int m, input int k);
        longint r;
        r = x >>> GT[m][k][0];
        if (GT[m][k][2] != 0) r = r + (x >>> GT[m][k][1]);
        return bsat(r);
    endfunction

    task automatic model_one(input int m, input longint v, input longint n, input longint s,
                             output longint vn, output longint nn, output bit sp);
        longint p, f, g, dv, dn;
        p = bsat((v * v) >>> 12);
        if (v < 0) begin
            f = bsat(-kg(p, m, 0));
            g = kg(p, m, 3);
        end else begin
            f = bsat(kg(p, m, 1) - kg(v, m, 2));
            g = kg(p, m, 4);
        end
        dv = bsat(f - n + BIAS[m] + s);
        dn = bsat(g - n);
        vn = bsat(v + kg(dv, m, 5));
        nn = bsat(n + kg(dn, m, 6));
        sp = (v <= 0) && (vn > 0);
    endtask

    function automatic longint rd_v(input int i);
        logic signed [DW-1:0] t;
        t = v_o[i*DW +: DW];
        return longint'(t);
    endfunction

    function automatic longint rd_n(input int i);
        logic signed [DW-1:0] t;
        t = n_o[i*DW +: DW];
        return longint'(t);
    endfunction

    // monitor: pops one expected item per neuron at every completion pulse
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done_o) begin
                if (sb.size() < N) begin
                    chk(1'b0, "R9", "unexpected pass", sb.size(), N);
                end else begin
                    for (int k = 0; k < N; k++) begin
                        exp_t e;
                        e = sb.pop_front();
                        chk(rd_v(k) == e.v, e.tag, $sformatf("v[%0d]", k), rd_v(k), e.v);
                        chk(rd_n(k) == e.n, "R3", $sformatf("n[%0d]", k), rd_n(k), e.n);
                        chk(spike_o[k] == e.s, "R6", $sformatf("spike[%0d]", k), spike_o[k], e.s);
                    end
                end
                pass_cnt++;
            end
        end
    end

    // driver: computes expectations, pushes them, runs one pass
    task automatic run_pass(input int m, input bit poke, input string tag);
        longint ov [N];
        int     cyc;
        for (int k = 0; k < N; k++) begin
            exp_t   e;
            longint vn, nn;
            bit     sp;
            ov[k] = mv[k];
            model_one(m, mv[k], mn[k], longint'(stim_a[k]), vn, nn, sp);
            mv[k] = vn;
            mn[k] = nn;
            e.v = vn;
            e.n = nn;
            e.s = sp;
            e.tag = tag;
            sb.push_back(e);
        end
        @(negedge clk);
        class_sel_i = m[0];
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 3) begin
                step_i = 1'b1;
                class_sel_i = ~m[0];
            end
            if (poke && cyc == 4) begin
                step_i = 1'b0;
                class_sel_i = m[0];
            end
            if (cyc == 8) begin
                // R7: neurons 0..7 updated, 8 not yet
                chk(rd_v(7) == mv[7], "R7", "v[7] mid-pass", rd_v(7), mv[7]);
                chk(rd_v(8) == ov[8], "R7", "v[8] mid-pass", rd_v(8), ov[8]);
            end
        end while (!done_o);
        chk(cyc == 16, "R8", "cycles to done", cyc, 16);
        exp_passes++;
        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done width", done_o, 0);
    endtask

    task automatic set_stim_all(input longint s);
        for (int k = 0; k < N; k++) stim_a[k] = DW'(s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) begin
            mv[k] = 0;
            mn[k] = 0;
        end
        set_stim_all(0);
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(v_o == '0 && n_o == '0, "R1", "state in reset", 0, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(v_o == '0 && n_o == '0, "R1", "state after reset", 0, 0);
        chk(spike_o == '0, "R1", "spike after reset", spike_o, 0);
        chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);

        // R6: strong drive from rest makes every neuron cross zero
        set_stim_all(4096);
        run_pass(0, 1'b0, "R4");
        chk(spike_o == 16'hFFFF, "R6", "first crossing", spike_o, 16'hFFFF);
        for (int r = 0; r < 5; r++) run_pass(0, 1'b0, "R4");
        chk(spike_o == 16'h0000, "R6", "no repeat while positive", spike_o, 0);

        // R3 / R4: per-neuron stimulus spread over both branches
        for (int k = 0; k < N; k++) stim_a[k] = DW'((k - 8) * 700);
        for (int r = 0; r < 6; r++) run_pass(0, 1'b0, "R4");
        set_stim_all(-20000);
        for (int r = 0; r < 4; r++) run_pass(0, 1'b0, "R3");
        set_stim_all(6000);
        for (int r = 0; r < 4; r++) run_pass(0, 1'b0, "R6");

        // R5: class 2 constant set
        for (int k = 0; k < N; k++) stim_a[k] = DW'((k - 4) * 900);
        for (int r = 0; r < 10; r++) run_pass(1, 1'b0, "R5");

        // R2: extreme drive both ways
        set_stim_all(-131072);
        for (int r = 0; r < 6; r++) run_pass(0, 1'b0, "R2");
        set_stim_all(131071);
        for (int r = 0; r < 20; r++) run_pass(1, 1'b0, "R2");
        chk(rd_v(0) == mv[0], "R2", "clamped v[0]", rd_v(0), mv[0]);

        // R5 / R9: strobe and mode flip during a pass are ignored
        for (int k = 0; k < N; k++) stim_a[k] = DW'(k * 300 - 2000);
        run_pass(0, 1'b1, "R5");
        repeat (30) @(negedge clk);
        chk(pass_cnt == exp_passes, "R9", "pass count after poke", pass_cnt, exp_passes);
        for (int k = 0; k < N; k++)
            chk(rd_v(k) == mv[k], "R9", $sformatf("idle v[%0d]", k), rd_v(k), mv[k]);
        chk(sb.size() == 0, "R9", "leftover expectations", sb.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule